// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous requester and an asynchronous static memory. The requester presents one read or write at a time with a single-cycle strobe, together with an address, write data and per-byte lane enables. The controller turns each request into a timed sequence on the memory pins: two chip enables (one active low, one active high), an active-low write strobe, an active-low output enable, active-low byte-lane enables, and write data with a drive-enable flag. A pad ring outside this block turns that flag into a tri-state buffer.

Every memory timing limit is a parameter in nanoseconds. At elaboration each limit is divided by the clock period and rounded up to a whole number of cycles. A loadable down-counter then times each phase of the state machine. Writes pass through setup, pulse, hold and recover phases. Reads pass through access and sample phases. The controller reports itself busy until the minimum cycle time has elapsed. Read data is returned with a one-cycle valid pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and when idle, `ready` is 1, `sram_ce_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dout_en`=0, `rd_valid`=0 and every bit of `sram_lane_n` is 1.
- R2: For a write, the address and both chip enables become active SETUP_CYC = max(1, ceil(T_AS/Tclk)) cycles before `sram_we_n` falls. The address does not change while `sram_we_n` is low, and `sram_we_n` is low only while both chip enables are active.
- R3: `sram_we_n` stays low for exactly max(1, ceil(T_WP/Tclk), ceil(T_DW/Tclk)) consecutive cycles per write.
- R4: `sram_dout_en` is 1 and `sram_dout` equals the request's write data from the cycle in which `sram_we_n` falls until HOLD_CYC = max(1, ceil(T_DH/Tclk)) cycles after it rises. After that it is 0.
- R5: `sram_oe_n` stays 1 throughout a write, and `sram_dout_en` is never 1 while `sram_oe_n` is 0.
- R6: After an accepted write, `ready` stays 0 for SETUP+PULSE+HOLD+max(1, ceil(T_WC/Tclk)−(SETUP+PULSE+HOLD)) cycles.
- R7: For a read, both chip enables and `sram_oe_n` are active for ACC_CYC = max(1, ceil(T_AA/Tclk), ceil(T_OE/Tclk)) cycles. `sram_din` is captured on the edge that ends this window, and `rd_valid` is 1 for exactly the next cycle with `rd_data` holding the captured word.
- R8: After an accepted read, `ready` stays 0 for ACC_CYC + max(1, ceil(T_RC/Tclk)−ACC_CYC) cycles.
- R9: A request is accepted only on a rising clock edge where `req_valid` and `ready` are both 1. A strobe while busy has no effect on the memory.
- R10: `sram_lane_n[i]` is 0 exactly when the chip is selected and `req_be[i]` was 1 for the accepted request. Lane 0 covers data bits 7:0 and lane 1 covers bits 15:8. A write changes only the enabled lanes of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, active high |
| ready | output | 1 | High when a request can be accepted |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle read-data strobe |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ce | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lane_n | output | DATA_W/8 | Byte-lane enables, active low |
| sram_dout | output | DATA_W | Data toward the memory |
| sram_dout_en | output | 1 | Drive enable for `sram_dout` |
| sram_din | input | DATA_W | Data from the memory |

## Verification
The bench's memory model returns a wrong word until the chip enables, the output enable and the address have all been stable for the full access count. A controller that samples one cycle early therefore returns bad data. The model commits a write only on the rising write strobe, using the data the controller drove during the pulse. A shortened pulse, missing hold, wrong lane gating or early data release therefore shows up as a wrong read-back.

The bench measures setup, pulse, hold and busy lengths at the pins and compares them with counts it derives from the nanosecond limits. A design with a mis-rounded or swapped phase count fails these checks. A strobe issued in the middle of a write targets a second address, so a controller that accepts requests while busy corrupts that address.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_RECOVER,
      ST_ACCESS,
      ST_SAMPLE
   } cyc_state_t;

   // nanoseconds to whole clock cycles, rounded up
   function automatic int ns_to_cyc(int ns, int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int at_least_one(int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int LANES = 2
) (
   input  logic             active,
   input  logic [LANES-1:0] be,
   output logic [LANES-1:0] lane_n
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g] = ~(active & be[g]);
   end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_cyc_pkg::*;
#(
   parameter int ADDR_W        = 19,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_AS_NS       = 0,
   parameter int T_WP_NS       = 50,
   parameter int T_DW_NS       = 30,
   parameter int T_DH_NS       = 0,
   parameter int T_WC_NS       = 70,
   parameter int T_AA_NS       = 70,
   parameter int T_OE_NS       = 35,
   parameter int T_RC_NS       = 70,
   localparam int LANES        = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce_n,
   output logic              sram_ce,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [LANES-1:0]  sram_lane_n,
   output logic [DATA_W-1:0] sram_dout,
   output logic              sram_dout_en,
   input  logic [DATA_W-1:0] sram_din
);
   // phase lengths in cycles
   localparam int SETUP_CYC = at_least_one(ns_to_cyc(T_AS_NS, CLK_PERIOD_NS));
   localparam int PULSE_CYC = at_least_one(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
   localparam int HOLD_CYC  = at_least_one(ns_to_cyc(T_DH_NS, CLK_PERIOD_NS));
   localparam int WR_USED   = SETUP_CYC + PULSE_CYC + HOLD_CYC;
   localparam int RECOV_CYC = at_least_one(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - WR_USED);
   localparam int ACC_CYC   = at_least_one(imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
   localparam int SAMP_CYC  = at_least_one(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - ACC_CYC);
   localparam int WR_TOTAL  = WR_USED + RECOV_CYC;
   localparam int RD_TOTAL  = ACC_CYC + SAMP_CYC;
   localparam int LONGEST   = imax(imax(imax(SETUP_CYC, PULSE_CYC), imax(HOLD_CYC, RECOV_CYC)),
                                   imax(ACC_CYC, SAMP_CYC));
   localparam int CNT_W     = $clog2(LONGEST) + 1;

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("sram_cycle_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clock
      $error("sram_cycle_ctrl: CLK_PERIOD_NS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_cycle_ctrl: ADDR_W must be at least 1");
   end

   cyc_state_t        state, nxt;
   logic              expired;
   logic              phase_load;
   logic [CNT_W-1:0]  phase_len;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;
   logic              selected;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:    if (req_valid) nxt = req_write ? ST_SETUP : ST_ACCESS;
         ST_SETUP:   if (expired) nxt = ST_PULSE;
         ST_PULSE:   if (expired) nxt = ST_HOLD;
         ST_HOLD:    if (expired) nxt = ST_RECOVER;
         ST_RECOVER: if (expired) nxt = ST_IDLE;
         ST_ACCESS:  if (expired) nxt = ST_SAMPLE;
         ST_SAMPLE:  if (expired) nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      phase_load = (nxt != state);
      unique case (nxt)
         ST_SETUP:   phase_len = CNT_W'(SETUP_CYC - 1);
         ST_PULSE:   phase_len = CNT_W'(PULSE_CYC - 1);
         ST_HOLD:    phase_len = CNT_W'(HOLD_CYC - 1);
         ST_RECOVER: phase_len = CNT_W'(RECOV_CYC - 1);
         ST_ACCESS:  phase_len = CNT_W'(ACC_CYC - 1);
         ST_SAMPLE:  phase_len = CNT_W'(SAMP_CYC - 1);
         default:    phase_len = '0;
      endcase
   end

   sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_load),
      .load_val (phase_len),
      .expired  (expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         state    <= nxt;
         rvalid_q <= 1'b0;
         if (state == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
         if (state == ST_ACCESS && expired) begin
            rdata_q  <= sram_din;
            rvalid_q <= 1'b1;
         end
      end
   end

   assign selected = (state == ST_SETUP) || (state == ST_PULSE) ||
                     (state == ST_HOLD)  || (state == ST_ACCESS);

   sram_lane_gate #(.LANES(LANES)) i_lanes (
      .active (selected),
      .be     (be_q),
      .lane_n (sram_lane_n)
   );

   assign ready        = (state == ST_IDLE);
   assign rd_data      = rdata_q;
   assign rd_valid     = rvalid_q;
   assign sram_addr    = addr_q;
   assign sram_ce_n    = ~selected;
   assign sram_ce      = selected;
   assign sram_we_n    = (state != ST_PULSE);
   assign sram_oe_n    = (state != ST_ACCESS);
   assign sram_dout    = wdata_q;
   assign sram_dout_en = (state == ST_PULSE) || (state == ST_HOLD);
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 16,
   parameter int LANES    = 2,
   parameter int WR_TOTAL = 8,
   parameter int RD_TOTAL = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce_n,
   input logic              sram_ce,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic [LANES-1:0]  sram_lane_n,
   input logic [DATA_W-1:0] sram_dout,
   input logic              sram_dout_en
);
   logic        last_wr;
   logic [15:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_wr  <= 1'b0;
         busy_cnt <= '0;
      end else begin
         if (ready && req_valid) last_wr <= req_write;
         busy_cnt <= ready ? 16'd0 : busy_cnt + 16'd1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dout_en));

   assert_we_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_ce_n && sram_ce));

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> $stable(sram_addr));

   assert_setup_before_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $past(!sram_ce_n));

   assert_data_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_dout_en && $stable(sram_dout)));

   assert_hold_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> sram_dout_en);

   assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> !sram_dout_en);

   assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && last_wr) |-> (busy_cnt == 16'(WR_TOTAL)));

   assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_read_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && !last_wr) |-> (busy_cnt == 16'(RD_TOTAL)));

   assert_busy_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(sram_addr));

   assert_lanes_off_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce_n |-> (&sram_lane_n));

   assert_lanes_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_lane_n));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LANES    (LANES),
   .WR_TOTAL (WR_TOTAL),
   .RD_TOTAL (RD_TOTAL)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .ready        (ready),
   .rd_valid     (rd_valid),
   .sram_addr    (sram_addr),
   .sram_ce_n    (sram_ce_n),
   .sram_ce      (sram_ce),
   .sram_we_n    (sram_we_n),
   .sram_oe_n    (sram_oe_n),
   .sram_lane_n  (sram_lane_n),
   .sram_dout    (sram_dout),
   .sram_dout_en (sram_dout_en)
);

// File: tb/test_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module test_sram_cycle_ctrl;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NW = 1 << AW;
   localparam int TCLK = 10;
   localparam int AS = 15, WP = 50, DWT = 30, DH = 0, WC = 70;
   localparam int AA = 70, OE = 35, RC = 90;

   function automatic int cdiv(int ns);
      return (ns + TCLK - 1) / TCLK;
   endfunction
   function automatic int mx(int a, int b);
      return a > b ? a : b;
   endfunction

   localparam int S_EXP   = mx(1, cdiv(AS));
   localparam int P_EXP   = mx(1, mx(cdiv(WP), cdiv(DWT)));
   localparam int H_EXP   = mx(1, cdiv(DH));
   localparam int WR_EXP  = S_EXP + P_EXP + H_EXP + mx(1, cdiv(WC) - (S_EXP + P_EXP + H_EXP));
   localparam int ACC_EXP = mx(1, mx(cdiv(AA), cdiv(OE)));
   localparam int RD_EXP  = ACC_EXP + mx(1, cdiv(RC) - ACC_EXP);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dout_en;
   logic [1:0]    sram_lane_n;
   logic [DW-1:0] sram_dout;
   logic [DW-1:0] sram_din = 16'hBAD0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sram_cycle_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(TCLK),
      .T_AS_NS(AS), .T_WP_NS(WP), .T_DW_NS(DWT), .T_DH_NS(DH), .T_WC_NS(WC),
      .T_AA_NS(AA), .T_OE_NS(OE), .T_RC_NS(RC)
   ) i_sram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_lane_n(sram_lane_n),
      .sram_dout(sram_dout), .sram_dout_en(sram_dout_en), .sram_din(sram_din)
   );

   // memory model: returns garbage until access time is met, commits on rising write strobe
   logic [DW-1:0] model [NW];
   logic [DW-1:0] exp_mem [NW];
   logic [DW-1:0] last_wr;
   logic [AW-1:0] prev_addr = '0;
   logic          prev_we_n = 1'b1;
   int            age = 0;

   initial begin
      for (int a = 0; a < NW; a++) begin
         model[a]   = 16'(a * 16'h1111) ^ 16'h5A5A;
         exp_mem[a] = 16'(a * 16'h1111) ^ 16'h5A5A;
      end
   end

   always @(negedge clk) begin
      logic sel;
      sel = !sram_ce_n && sram_ce;
      if (sel && !sram_oe_n && sram_we_n)
         age = (age > 0 && sram_addr == prev_addr) ? age + 1 : 1;
      else
         age = 0;
      if (age >= ACC_EXP)
         sram_din <= {sram_lane_n[1] ? 8'h00 : model[sram_addr][15:8],
                      sram_lane_n[0] ? 8'h00 : model[sram_addr][7:0]};
      else
         sram_din <= 16'hBAD0;
      if (!sram_we_n)
         last_wr = sram_dout_en ? sram_dout : 16'hxxxx;
      if (!prev_we_n && sram_we_n && sel) begin
         if (!sram_lane_n[0]) model[sram_addr][7:0]  = last_wr[7:0];
         if (!sram_lane_n[1]) model[sram_addr][15:8] = last_wr[15:8];
      end
      prev_we_n = sram_we_n;
      prev_addr = sram_addr;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be,
                           bit inject, logic [AW-1:0] other);
      int n = 0, setup = 0, pulse = 0, hold = 0;
      bit seen_low = 0, data_bad = 0, oe_bad = 0, lane_bad = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!ready) begin
         n++;
         if (!sram_ce_n && sram_ce && sram_we_n && !seen_low) setup++;
         if (!sram_we_n) begin
            pulse++;
            seen_low = 1;
            if (!sram_dout_en || sram_dout !== d) data_bad = 1;
         end
         if (seen_low && sram_we_n && sram_dout_en) begin
            hold++;
            if (sram_dout !== d) data_bad = 1;
         end
         if (!sram_oe_n) oe_bad = 1;
         if (!sram_ce_n && sram_lane_n !== ~be) lane_bad = 1;
         if (inject && n == 2) begin
            req_valid = 1'b1; req_addr = other; req_wdata = ~d; req_be = 2'b11;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      check("R2 setup cycles", setup, S_EXP);
      check("R3 pulse cycles", pulse, P_EXP);
      check("R4 hold cycles", hold, H_EXP);
      check("R4 data during pulse", data_bad, 0);
      check("R4 released at idle", sram_dout_en, 0);
      check("R5 oe high in write", oe_bad, 0);
      check("R6 write busy", n, WR_EXP);
      check("R10 lane enables", lane_bad, 0);
      if (be[0]) exp_mem[a][7:0]  = d[7:0];
      if (be[1]) exp_mem[a][15:8] = d[15:8];
   endtask

   task automatic do_read(logic [AW-1:0] a, logic [1:0] be);
      int n = 0, acc = 0, vcount = 0, vpos = 0;
      bit drv_bad = 0;
      logic [DW-1:0] got = '0;
      logic [DW-1:0] want;
      want = {be[1] ? exp_mem[a][15:8] : 8'h00, be[0] ? exp_mem[a][7:0] : 8'h00};
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!ready) begin
         n++;
         if (!sram_ce_n && sram_ce && !sram_oe_n) acc++;
         if (sram_dout_en) drv_bad = 1;
         if (rd_valid) begin
            vcount++;
            vpos = n;
            got = rd_data;
         end
         @(negedge clk);
      end
      if (rd_valid) vcount++;
      check("R7 access cycles", acc, ACC_EXP);
      check("R7 valid count", vcount, 1);
      check("R7 valid position", vpos, ACC_EXP + 1);
      check("R10 read data", got, want);
      check("R5 no drive in read", drv_bad, 0);
      check("R8 read busy", n, RD_EXP);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1 ready", ready, 1);
      check("R1 ce_n", sram_ce_n, 1);
      check("R1 ce", sram_ce, 0);
      check("R1 we_n", sram_we_n, 1);
      check("R1 oe_n", sram_oe_n, 1);
      check("R1 lanes", sram_lane_n, 2'b11);
      check("R1 dout_en", sram_dout_en, 0);
      check("R1 rd_valid", rd_valid, 0);
      rst_n = 1'b1;
      // write sweep over all addresses and all lane patterns
      for (int a = 0; a < NW; a++)
         do_write(AW'(a), 16'(a * 16'h0F1D + 16'h3C00), 2'(a), 1'b0, '0);
      for (int a = 0; a < NW; a++)
         do_read(AW'(a), 2'b11);
      // single-lane reads
      do_read(AW'(7), 2'b01);
      do_read(AW'(7), 2'b10);
      // R9: strobe while busy aimed at another address must be ignored
      do_write(AW'(5), 16'hC3A1, 2'b11, 1'b1, AW'(9));
      do_read(AW'(9), 2'b11);
      do_read(AW'(5), 2'b11);
      check("R9 idle after busy strobe", ready, 1);
      // back-to-back write then read of the same word
      do_write(AW'(15), 16'h0001, 2'b11, 1'b0, '0);
      do_read(AW'(15), 2'b11);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule